// File: doc/BRIEF.md
# Multiplexed Address/Data I/O Port

This block controls one 8-bit port of an 8051-compatible core. The port has two uses. As general-purpose I/O it is open-drain and its pins follow a port latch that software writes. During external memory cycles it becomes a shared bus and carries either the low byte of the address or the data byte. For each pin it produces a drive-enable and a drive value for the pad. Reads of the port register return either the synchronised pin levels or, for read-modify-write accesses, the latch itself.

The core's page-mode controls decide which bus role the port takes. With page mode off, the port owns no bus phases while code runs inside internal ROM. Once code runs above that limit it becomes a multiplexed address-low/data bus. With page mode on, a page-select value of 3 makes the port an address-only bus, and any other value makes it a data-only bus. Phases that the current role does not use leave the port in its open-drain latch behaviour. The latch is never lost while the port serves as a bus.

Top module: `adbus_port`

## Requirements
- R1: After reset the latch holds all ones. With no bus phase in use, every `pad_oe` bit is 0 and a read-modify-write read returns FFh.
- R2: When no bus phase claims the port, `pad_out` is 0 and `pad_oe[i]` is the inverse of latch bit i. A 0 bit pulls the pin low and a 1 bit releases it.
- R3: A plain read (`sfr_rd`=1, `rmw`=0) returns `pin_in` through two flops. A level present at clock edge k is visible after edge k+1 and not earlier. The read does not alter the latch.
- R4: A read with `rmw`=1 returns the latch. While `sfr_rd` is 0, `sfr_rdata` is 0.
- R5: A write (`sfr_wr`=1) loads `sfr_wdata` into the latch at that clock edge. A read-modify-write read in the same cycle returns the value held before the update.
- R6: With `page_en`=0 and `code_above`=0, all phase inputs are ignored. With `page_en`=0 and `code_above`=1, the port is multiplexed: an address phase drives `bus_addr`, a write phase drives `bus_wdata`, and in both cases `pad_oe` is all ones. A read phase sets `pad_oe` to all zeros.
- R7: With `page_en`=1 and `page_sel` at 0, 1 or 2, the port is data-only. A write phase drives `bus_wdata` and a read phase floats all pins. An address phase is ignored.
- R8: With `page_en`=1 and `page_sel`=3, the port is address-only. An address phase drives `bus_addr` on all pins, and data phases are ignored.
- R9: When several phases are asserted together, the port serves the phase its role accepts with the highest priority. The order is address, then write, then read.
- R10: Bus use does not change the latch. When the phases drop, the pins return to the latch-driven open-drain state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_wr | input | 1 | Port register write strobe |
| sfr_wdata | input | 8 | Port register write data |
| sfr_rd | input | 1 | Port register read strobe |
| rmw | input | 1 | Current read belongs to a read-modify-write access |
| page_en | input | 1 | Page mode enable |
| page_sel | input | 2 | Page mode select field |
| code_above | input | 1 | Code is executing above the internal ROM limit |
| ph_addr | input | 1 | External cycle address phase |
| ph_wr | input | 1 | External data-write phase |
| ph_rd | input | 1 | External data-read phase |
| bus_addr | input | 8 | Address low byte from the core |
| bus_wdata | input | 8 | Write data from the core |
| pin_in | input | 8 | Pin levels from the pads |
| pad_oe | output | 8 | Per-pin drive enable |
| pad_out | output | 8 | Per-pin drive value |
| sfr_rdata | output | 8 | Port register read data |

## Verification
A corrupted latch shows up at once in `pad_oe` on any cycle the port is idle, and on the first read-modify-write read. A wrong role decode affects only `pad_oe` and `pad_out`, and it does so in the same cycle the phase is asserted. For that reason the bench sweeps every combination of page-enable, page-select, code-limit flag and phase, over several latch patterns. A fault in the synchroniser shows up as a plain read that arrives one cycle early or late, or not at all. The bench therefore samples each cycle of the two-edge window.

// File: rtl/adbus_port_pkg.sv
package adbus_port_pkg;

    // Which source owns the pads in the current cycle
    typedef enum logic [1:0] {
        DRV_LATCH = 2'd0,   // open-drain from the port latch
        DRV_ADDR  = 2'd1,   // push-pull address low byte
        DRV_WDATA = 2'd2,   // push-pull write data
        DRV_FLOAT = 2'd3    // all pins released for a data read
    } drive_sel_e;

    // Bus role chosen by the page controls
    typedef enum logic [1:0] {
        ROLE_GPIO = 2'd0,
        ROLE_MUX  = 2'd1,
        ROLE_DATA = 2'd2,
        ROLE_ADDR = 2'd3
    } port_role_e;

    localparam logic [1:0] PAGE_SEL_ADDR_ONLY = 2'b11;

endpackage

// File: rtl/adbus_port_sync.sv
module adbus_port_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stage;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stage[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stage[i] = s_q.stage[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_out = s_q.stage[LAST];

endmodule

// File: rtl/adbus_port_mode.sv
module adbus_port_mode
    import adbus_port_pkg::*;
(
    input  logic       page_en,
    input  logic [1:0] page_sel,
    input  logic       code_above,
    input  logic       ph_addr,
    input  logic       ph_wr,
    input  logic       ph_rd,
    output drive_sel_e drive_sel
);
    port_role_e role;
    logic       takes_addr;
    logic       takes_data;

    always_comb begin
        if (page_en) begin
            role = (page_sel == PAGE_SEL_ADDR_ONLY) ? ROLE_ADDR : ROLE_DATA;
        end else if (code_above) begin
            role = ROLE_MUX;
        end else begin
            role = ROLE_GPIO;
        end
    end

    always_comb begin
        takes_addr = (role == ROLE_MUX) || (role == ROLE_ADDR);
        takes_data = (role == ROLE_MUX) || (role == ROLE_DATA);
    end

    // Priority among accepted phases: address, write, read
    always_comb begin
        if (ph_addr && takes_addr) begin
            drive_sel = DRV_ADDR;
        end else if (ph_wr && takes_data) begin
            drive_sel = DRV_WDATA;
        end else if (ph_rd && takes_data) begin
            drive_sel = DRV_FLOAT;
        end else begin
            drive_sel = DRV_LATCH;
        end
    end

endmodule

// File: rtl/adbus_port_drive.sv
module adbus_port_drive
    import adbus_port_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  drive_sel_e   drive_sel,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out
);
    for (genvar b = 0; b < W; b++) begin : g_pin
        always_comb begin
            unique case (drive_sel)
                DRV_ADDR: begin
                    pad_oe[b]  = 1'b1;
                    pad_out[b] = bus_addr[b];
                end
                DRV_WDATA: begin
                    pad_oe[b]  = 1'b1;
                    pad_out[b] = bus_wdata[b];
                end
                DRV_FLOAT: begin
                    pad_oe[b]  = 1'b0;
                    pad_out[b] = 1'b0;
                end
                default: begin
                    // open drain: only a 0 is driven
                    pad_oe[b]  = ~latch[b];
                    pad_out[b] = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/adbus_port.sv
module adbus_port
    import adbus_port_pkg::*;
#(
    parameter int unsigned W           = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sfr_wr,
    input  logic [W-1:0] sfr_wdata,
    input  logic         sfr_rd,
    input  logic         rmw,
    input  logic         page_en,
    input  logic [1:0]   page_sel,
    input  logic         code_above,
    input  logic         ph_addr,
    input  logic         ph_wr,
    input  logic         ph_rd,
    input  logic [W-1:0] bus_addr,
    input  logic [W-1:0] bus_wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] sfr_rdata
);
    localparam logic [W-1:0] LATCH_RST = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] latch;
    } port_state_t;

    port_state_t st_d, st_q;
    drive_sel_e  drive_sel;
    logic [W-1:0] pin_sync;

    always_comb begin
        st_d = st_q;
        if (sfr_wr) begin
            st_d.latch = sfr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch <= LATCH_RST;
        end else begin
            st_q <= st_d;
        end
    end

    adbus_port_sync #(
        .W      (W),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    adbus_port_mode mode_i (
        .page_en    (page_en),
        .page_sel   (page_sel),
        .code_above (code_above),
        .ph_addr    (ph_addr),
        .ph_wr      (ph_wr),
        .ph_rd      (ph_rd),
        .drive_sel  (drive_sel)
    );

    adbus_port_drive #(
        .W (W)
    ) drive_i (
        .drive_sel (drive_sel),
        .latch     (st_q.latch),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    // read-modify-write sees the latch held before any same-cycle write
    always_comb begin
        if (!sfr_rd) begin
            sfr_rdata = '0;
        end else if (rmw) begin
            sfr_rdata = st_q.latch;
        end else begin
            sfr_rdata = pin_sync;
        end
    end

endmodule

// File: rtl/adbus_port_chk.sv
module adbus_port_chk #(
    parameter int unsigned W           = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sfr_wr,
    input logic [W-1:0] sfr_wdata,
    input logic         sfr_rd,
    input logic         rmw,
    input logic         page_en,
    input logic [1:0]   page_sel,
    input logic         code_above,
    input logic         ph_addr,
    input logic         ph_wr,
    input logic         ph_rd,
    input logic [W-1:0] bus_addr,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] sfr_rdata
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R2: pins not driven push-pull are never driven high
    assert_open_drain_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe != {W{1'b1}}) |-> (pad_out == '0));

    // R5: a written value is what the next read-modify-write read returns
    assert_write_next_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_wr |=> (!(sfr_rd && rmw) || (sfr_rdata == $past(sfr_wdata))));

    // R8: address-only page drives the address byte on every pin
    assert_addr_only_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (page_en && (page_sel == 2'b11) && ph_addr) |->
            ((pad_oe == {W{1'b1}}) && (pad_out == bus_addr)));

    // R7: a lone read phase in a data-carrying role floats the port
    assert_read_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_rd && !ph_addr && !ph_wr && (page_en || code_above) &&
         !(page_en && (page_sel == 2'b11))) |-> (pad_oe == '0));

    // R6: no bus ownership means nothing is driven high
    assert_gpio_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_en && !code_above) |-> (pad_out == '0));

    // R3: plain read shows pins from two edges earlier
    if (SYNC_STAGES == 2) begin : g_sync_chk
        assert_sync_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ((since_rst >= 2'd2) && sfr_rd && !rmw) |-> (sfr_rdata == $past(pin_in, 2)));
    end

endmodule

bind adbus_port adbus_port_chk #(.W(W), .SYNC_STAGES(SYNC_STAGES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sfr_wr     (sfr_wr),
    .sfr_wdata  (sfr_wdata),
    .sfr_rd     (sfr_rd),
    .rmw        (rmw),
    .page_en    (page_en),
    .page_sel   (page_sel),
    .code_above (code_above),
    .ph_addr    (ph_addr),
    .ph_wr      (ph_wr),
    .ph_rd      (ph_rd),
    .bus_addr   (bus_addr),
    .pin_in     (pin_in),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .sfr_rdata  (sfr_rdata)
);

// File: tb/adbus_port_tb_top.sv
module adbus_port_tb_top;
    localparam int W        = 8;
    localparam int CLK_PER  = 10;
    localparam int WD_LIMIT = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sfr_wr = 1'b0;
    logic [W-1:0] sfr_wdata = '0;
    logic         sfr_rd = 1'b0;
    logic         rmw = 1'b0;
    logic         page_en = 1'b0;
    logic [1:0]   page_sel = '0;
    logic         code_above = 1'b0;
    logic         ph_addr = 1'b0;
    logic         ph_wr = 1'b0;
    logic         ph_rd = 1'b0;
    logic [W-1:0] bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] pin_in = '1;
    logic [W-1:0] pad_oe;
    logic [W-1:0] pad_out;
    logic [W-1:0] sfr_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    adbus_port dut_i (
        .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .sfr_rd(sfr_rd), .rmw(rmw), .page_en(page_en), .page_sel(page_sel),
        .code_above(code_above), .ph_addr(ph_addr), .ph_wr(ph_wr), .ph_rd(ph_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_in(pin_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .sfr_rdata(sfr_rdata)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rmw_read(output logic [W-1:0] v);
        sfr_rd = 1'b1; rmw = 1'b1; #1;
        v = sfr_rdata;
        sfr_rd = 1'b0; rmw = 1'b0; #1;
    endtask

    task automatic write_latch(input logic [W-1:0] v);
        sfr_wr = 1'b1; sfr_wdata = v;
        step();
        sfr_wr = 1'b0;
    endtask

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] latch_vals [4];
        latch_vals[0] = 8'hFF; latch_vals[1] = 8'h00;
        latch_vals[2] = 8'hA5; latch_vals[3] = 8'h3C;

        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        #1;
        chk("R1 oe after reset", pad_oe, 8'h00);
        chk("R1 out after reset", pad_out, 8'h00);
        rmw_read(v);
        chk("R1 latch after reset", v, 8'hFF);

        // R4 idle read data is zero
        chk("R4 rdata idle", sfr_rdata, 8'h00);

        // R3 synchroniser latency
        pin_in = 8'h96;
        sfr_rd = 1'b1; #1;
        chk("R3 before any edge", sfr_rdata, 8'hFF);
        step(); #1;
        chk("R3 after one edge", sfr_rdata, 8'hFF);
        step(); #1;
        chk("R3 after two edges", sfr_rdata, 8'h96);
        sfr_rd = 1'b0;
        rmw_read(v);
        chk("R3 latch untouched by read", v, 8'hFF);

        // R5 write with same-cycle read-modify-write read
        sfr_wr = 1'b1; sfr_wdata = 8'h5E; sfr_rd = 1'b1; rmw = 1'b1; #1;
        chk("R5 same-cycle rmw sees old", sfr_rdata, 8'hFF);
        step();
        sfr_wr = 1'b0; #1;
        chk("R5 next cycle sees new", sfr_rdata, 8'h5E);
        sfr_rd = 1'b0; rmw = 1'b0; #1;
        chk("R2 oe follows latch", pad_oe, 8'hA1);

        // R6..R9, R2, R10 sweep over latch, page controls and phases
        for (int li = 0; li < 4; li++) begin
            write_latch(latch_vals[li]);
            for (int pe = 0; pe < 2; pe++) begin
                for (int ps = 0; ps < 4; ps++) begin
                    for (int ca = 0; ca < 2; ca++) begin
                        for (int ph = 0; ph < 8; ph++) begin
                            logic own, a_ok, d_ok;
                            logic [W-1:0] e_oe, e_out;
                            string tag;
                            page_en = pe[0]; page_sel = ps[1:0]; code_above = ca[0];
                            ph_addr = ph[0]; ph_wr = ph[1]; ph_rd = ph[2];
                            bus_addr  = 8'h5A ^ W'(li * 17 + ph);
                            bus_wdata = 8'hC3 ^ W'(ps * 29 + ca);
                            own  = pe[0] | ca[0];
                            a_ok = own & (!pe[0] | (ps == 3));
                            d_ok = own & (!pe[0] | (ps != 3));
                            if (ph[0] && a_ok) begin
                                e_oe = 8'hFF; e_out = bus_addr;
                            end else if (ph[1] && d_ok) begin
                                e_oe = 8'hFF; e_out = bus_wdata;
                            end else if (ph[2] && d_ok) begin
                                e_oe = 8'h00; e_out = 8'h00;
                            end else begin
                                e_oe = ~latch_vals[li]; e_out = 8'h00;
                            end
                            if (!own) tag = "R6 gpio";
                            else if (!pe[0]) tag = "R6 mux";
                            else if (ps == 3) tag = "R8 addr-only";
                            else tag = "R7 data-only";
                            if ($countones(ph) > 1) tag = {tag, " R9 priority"};
                            #1;
                            chk({tag, " oe"}, pad_oe, e_oe);
                            chk({tag, " out"}, pad_out, e_out);
                            step();
                        end
                    end
                end
            end
            ph_addr = 1'b0; ph_wr = 1'b0; ph_rd = 1'b0; #1;
            chk("R10 oe after bus use", pad_oe, ~latch_vals[li]);
            chk("R2 out after bus use", pad_out, 8'h00);
            rmw_read(v);
            chk("R10 latch kept", v, latch_vals[li]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule